// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls one 8-pin general-purpose I/O port from a simple memory-mapped register bus. A single 32-bit data word holds four byte lanes: the per-pin direction, the output value, the pin levels captured just after reset, and the live pin levels. Software writes the first two lanes and reads all four. The block drives an output-enable vector and an output-value vector to the pads. It samples the pad inputs through a two-flop synchronizer.

Two write-only alias addresses change single output bits without a read-modify-write. A 1 written to the set alias drives the matching output bit high, and a 1 written to the clear alias drives it low. Zeros written to either alias leave the bits as they were. A fourth register holds per-pin pull-up enables. One pin, chosen by a parameter, always has its pull-up enabled.

The port occupies a 16-byte window. Word address bits 3:2 select the register as follows: 0x0 is the data word, 0x4 the set alias, 0x8 the clear alias and 0xC the pull-up register. Address bits 1:0 are ignored.

Top module: `pin_port_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, direction, output value and stored pull-up enables are all 0. So pad_oe and pad_out are 0, and pad_pullup has only the forced pin set.
- R2: A bus write to offset 0x0 loads direction from bits 31:24 and the output value from bits 23:16. A direction bit of 1 makes its pin an output (pad_oe bit 1). Write bits 15:0 are ignored. The new values appear on pad_oe, pad_out and the read data after the same clock edge.
- R3: Read bits 15:8 of offset 0x0 return the synchronized pin levels loaded on the third rising clock edge after reset release. These are the pin levels present at the first edge after release. They hold unchanged until the next reset, whatever the pins do afterwards.
- R4: Read bits 7:0 of offset 0x0 return the pad inputs delayed by two rising clock edges. A change driven before edge N is visible after edge N+1 and not after edge N.
- R5: A write to offset 0x4 ORs write bits 23:16 into the output value. Zero bits leave their outputs unchanged, and all other write bits, including the direction lane, are ignored.
- R6: A write to offset 0x8 clears each output-value bit whose write bit in 23:16 is 1. Zero bits and all other write bits have no effect.
- R7: Offset 0xC holds per-pin pull-up enables in bits 7:0. It is read/write, and it resets to 0. Bits 31:8 of the write are ignored and read as 0. pad_pullup reflects the enables.
- R8: The pin chosen by FIXED_PIN (default pin 2) always has pad_pullup set, and reads back as 1 at offset 0xC, even after 0 is written to it.
- R9: Reads at offsets 0x4 and 0x8 return 0, and read data is 0 while bus_sel is low. Address bits 1:0 do not affect decode.
- R10: A cycle with bus_sel or bus_wr low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Port window selected for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the port window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address and state) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pullup | output | 8 | Per-pin pull-up enable |

## Verification
Random sequences mix full data-word writes, set and clear alias writes with random masks, pull-up writes and reads. The random address low bits test that byte-offset bits 1:0 are ignored. The random data in unused lanes tests that those lanes are ignored. Several directed cases check single edges. One alias write uses an all-zero mask and must not differ from an idle cycle. One alias write carries a full direction lane, which tells whether the alias only touches the output lane. One pin change is sampled after one edge and again after two, which tells whether the input delay is exactly two edges. Two resets with different pin levels tell a latched snapshot apart from a live copy.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

    // Register selected by byte-offset bits 3:2 of the port window
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_PULL = 2'd3
    } reg_sel_e;

    // Byte lane positions inside the 32-bit data word
    localparam int LANE_W    = 8;
    localparam int LANE_DIR  = 24;
    localparam int LANE_OUT  = 16;
    localparam int LANE_SNAP = 8;
    localparam int LANE_LIVE = 0;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
    import pin_port_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int SETTLE = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        sel,
    input  logic [31:0]     wdata,
    input  logic [PINS-1:0] sync_in,
    output logic [PINS-1:0] dir,
    output logic [PINS-1:0] dout,
    output logic [PINS-1:0] pull,
    output logic [PINS-1:0] snap
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [PINS-1:0]  dir;
        logic [PINS-1:0]  dout;
        logic [PINS-1:0]  pull;
        logic [PINS-1:0]  snap;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                REG_DATA: begin
                    st_d.dir  = wdata[LANE_DIR +: PINS];
                    st_d.dout = wdata[LANE_OUT +: PINS];
                end
                REG_SET:  st_d.dout = st_q.dout | wdata[LANE_OUT +: PINS];
                REG_CLR:  st_d.dout = st_q.dout & ~wdata[LANE_OUT +: PINS];
                REG_PULL: st_d.pull = wdata[PINS-1:0];
                default:  ;
            endcase
        end
        // Let the synchronizer fill, then latch the pins once
        if (!st_q.done) begin
            if (st_q.cnt == CNT_W'(SETTLE)) begin
                st_d.snap = sync_in;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir  = st_q.dir;
    assign dout = st_q.dout;
    assign pull = st_q.pull;
    assign snap = st_q.snap;
endmodule

// File: rtl/port_rdmux.sv
module port_rdmux
    import pin_port_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            rd_en,
    input  reg_sel_e        sel,
    input  logic [PINS-1:0] dir,
    input  logic [PINS-1:0] dout,
    input  logic [PINS-1:0] snap,
    input  logic [PINS-1:0] live,
    input  logic [PINS-1:0] pull_eff,
    output logic [31:0]     rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                REG_DATA: begin
                    rdata[LANE_DIR  +: PINS] = dir;
                    rdata[LANE_OUT  +: PINS] = dout;
                    rdata[LANE_SNAP +: PINS] = snap;
                    rdata[LANE_LIVE +: PINS] = live;
                end
                REG_PULL: rdata[PINS-1:0] = pull_eff;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
    import pin_port_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FIXED_PIN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_pullup
);
    localparam logic [PINS-1:0] FORCED_MASK =
        (FIXED_PIN >= 0 && FIXED_PIN < PINS) ? (PINS'(1) << FIXED_PIN) : '0;

    reg_sel_e        sel;
    logic            wr_en;
    logic [PINS-1:0] live, dir, dout, pull, snap, pull_eff;

    assign sel   = reg_sel_e'(bus_addr[3:2]);
    assign wr_en = bus_sel && bus_wr;

    pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (live)
    );

    port_regs #(.PINS(PINS), .SETTLE(SYNC_STAGES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (bus_wdata),
        .sync_in (live),
        .dir     (dir),
        .dout    (dout),
        .pull    (pull),
        .snap    (snap)
    );

    assign pull_eff = pull | FORCED_MASK;

    port_rdmux #(.PINS(PINS)) u_rdmux (
        .rd_en    (bus_sel && !bus_wr),
        .sel      (sel),
        .dir      (dir),
        .dout     (dout),
        .snap     (snap),
        .live     (live),
        .pull_eff (pull_eff),
        .rdata    (bus_rdata)
    );

    assign pad_oe     = dir;
    assign pad_out    = dout;
    assign pad_pullup = pull_eff;
endmodule

// File: rtl/pin_port_ctrl_chk.sv
module pin_port_ctrl_chk #(
    parameter int PINS   = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_pullup
);
    logic [2:0] age_q;
    logic       settled, rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age_q <= '0;
        else if (!(&age_q)) age_q <= age_q + 3'd1;
    end

    assign settled = (age_q >= 3'd5);
    assign rd_data = bus_sel && !bus_wr && (bus_addr[3:2] == 2'd0);

    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

    a_r5_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[3:2] == 2'd1) |=>
        (pad_out == ($past(pad_out) | $past(bus_wdata[16 +: PINS])) && $stable(pad_oe)));

    a_r6_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[3:2] == 2'd2) |=>
        (pad_out == ($past(pad_out) & ~$past(bus_wdata[16 +: PINS])) && $stable(pad_oe)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pullup)));

    a_r9_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr[3:2] == 2'd1 || bus_addr[3:2] == 2'd2)) |->
        bus_rdata == 32'd0);

    a_r3_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && rd_data && $past(rd_data)) |-> $stable(bus_rdata[15:8]));
endmodule

bind pin_port_ctrl pin_port_ctrl_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pin_port_ctrl_test.sv
`timescale 1ns/1ps
module pin_port_ctrl_test;
    localparam int FIXED = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = 8'hA5;
    logic [7:0]  pad_oe, pad_out, pad_pullup;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model
    logic [7:0] m_dir, m_out, m_pull, m_snap;

    always #2.5 clk = ~clk;

    pin_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pullup(pad_pullup)
    );

    function automatic logic [7:0] pull_eff(input logic [7:0] p);
        return p | (8'd1 << FIXED);
    endfunction

    function automatic logic [31:0] exp_data(input logic [7:0] live);
        return {m_dir, m_out, m_snap, live};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        case (addr[3:2])
            2'd0: begin m_dir = data[31:24]; m_out = data[23:16]; end
            2'd1: m_out = m_out | data[23:16];
            2'd2: m_out = m_out & ~data[23:16];
            default: m_pull = data[7:0];
        endcase
    endtask

    task automatic bus_read(input logic [3:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        #1 data = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] pins);
        @(negedge clk);
        rst_n = 1'b0; pad_in = pins;
        m_dir = '0; m_out = '0; m_pull = '0; m_snap = pins;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_oe"},     {24'd0, pad_oe},     {24'd0, m_dir});
        check({req, " pad_out"},    {24'd0, pad_out},    {24'd0, m_out});
        check({req, " pad_pullup"}, {24'd0, pad_pullup}, {24'd0, pull_eff(m_pull)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int seed;
        seed = $urandom(32'h5EED_0042);

        // R1: values while reset is held
        m_dir = '0; m_out = '0; m_pull = '0; m_snap = 8'hA5;
        repeat (2) @(negedge clk);
        check_pads("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_pads("R1 after release");

        // R3 / R4: snapshot and live after reset
        bus_read(4'h0, rd);
        check("R3 snapshot after reset", rd, exp_data(8'hA5));

        // R4: exact two-edge delay
        @(negedge clk);
        pad_in = 8'h3C;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h0;
        #1 check("R4 live after one edge", {24'd0, bus_rdata[7:0]}, 32'h0000_00A5);
        @(negedge clk);
        #1 check("R4 live after two edges", {24'd0, bus_rdata[7:0]}, 32'h0000_003C);
        // R3: snapshot holds while pins moved
        check("R3 snapshot holds", {24'd0, bus_rdata[15:8]}, 32'h0000_00A5);
        bus_sel = 1'b0;

        // R2: data write, lower lanes ignored
        bus_write(4'h0, 32'hF0_5A_FF_FF);
        check_pads("R2 data write");
        bus_read(4'h0, rd);
        check("R2 data readback", rd, exp_data(8'h3C));

        // R5: set alias, zero mask, and direction lane ignored
        bus_write(4'h4, 32'hFF_00_FF_FF);
        check_pads("R5 zero-mask set");
        bus_write(4'h5, 32'h00_81_00_00);
        check_pads("R5 set alias");

        // R6: clear alias, zero mask
        bus_write(4'hA, 32'hFF_00_FF_FF);
        check_pads("R6 zero-mask clear");
        bus_write(4'h8, 32'h00_42_00_00);
        check_pads("R6 clear alias");

        // R9: alias reads and deselected reads return 0
        bus_read(4'h4, rd);
        check("R9 set alias read", rd, 32'd0);
        bus_read(4'h8, rd);
        check("R9 clear alias read", rd, 32'd0);
        @(negedge clk);
        bus_addr = 4'h0; bus_sel = 1'b0;
        #1 check("R9 deselected read", bus_rdata, 32'd0);

        // R7 / R8: pull-up register and forced pin
        bus_write(4'hC, 32'hFFFF_FF00);
        check_pads("R8 forced pull-up only");
        bus_read(4'hC, rd);
        check("R8 forced pin reads 1", rd, {24'd0, pull_eff(8'h00)});
        bus_write(4'hF, 32'h0000_0031);
        bus_read(4'hC, rd);
        check("R7 pull readback", rd, {24'd0, pull_eff(8'h31)});
        check_pads("R7 pull pads");

        // R10: write strobe without select, and select without write
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0;
        check_pads("R10 no strobe");

        // Random mix of all register operations
        for (int i = 0; i < 400; i++) begin
            logic [31:0] wd;
            logic [3:0]  ad;
            wd = $urandom;
            ad = 4'($urandom);
            if (i % 60 == 59) begin
                @(negedge clk);
                pad_in = 8'($urandom);
                repeat (3) @(negedge clk);
            end
            if ($urandom % 4 == 0) begin
                bus_read(ad, rd);
                if (ad[3:2] == 2'd0)      check("R2 random read", rd, exp_data(pad_in));
                else if (ad[3:2] == 2'd3) check("R7 random read", rd, {24'd0, pull_eff(m_pull)});
                else                      check("R9 random read", rd, 32'd0);
            end else begin
                bus_write(ad, wd);
                case (ad[3:2])
                    2'd0: check_pads("R2 random");
                    2'd1: check_pads("R5 random");
                    2'd2: check_pads("R6 random");
                    default: check_pads("R7 random");
                endcase
            end
        end

        // R3: second reset with different pins captures fresh snapshot
        do_reset(8'h5A);
        check_pads("R1 second reset");
        bus_read(4'h0, rd);
        check("R3 snapshot second reset", rd, exp_data(8'h5A));
        @(negedge clk);
        pad_in = 8'hC3;
        repeat (4) @(negedge clk);
        bus_read(4'h0, rd);
        check("R3 snapshot after pin change", rd, exp_data(8'hC3));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule